// File: doc/BRIEF.md
# Multiplexed Host Bus Slave Interface

This block is the slave side of a 16-bit host bus on which address and data share the same sixteen lines. An address strobe marks the address phase. During that phase the block stores the 20-bit address, made of the shared lines plus four upper address bits. At the same moment it decides whether the coming cycle is addressed to it. That decision depends on four things: the active-low select, the program-fetch qualifier, the memory/IO qualifier and an address window.

A decoded cycle is then run by the active-low read or write strobe. The strobe drives a single-cycle access into a simple register-file port, with per-lane byte enables taken from the high-lane enable and address bit 0. The ready output is synchronous to the clock. It stays low at the start of every cycle and rises once the data can be moved. During the data phase of a decoded read, the block drives the shared lines through an output-enable; at all other times it leaves them undriven.

The window is set by two parameters, `WIN_BITS` and `BASE_ADDR`. A configuration input lets IO-type cycles be accepted as well as memory-type cycles.

Top module: `mux_host_slave`

## Requirements
- R1: While `addr_strobe` is high at a rising clock edge, the block stores `{addr_hi, mux_in}` as the cycle address. The register-file word index `rf_addr` equals address bits `[WIN_BITS-1:1]`.
- R2: A cycle whose `sel_n` is high during the address phase is never recognised: `ready` stays low, there is no register-file access, and `mux_oe` stays low.
- R3: A cycle whose `fetch_n` is low during the address phase is ignored in the same way as R2, even when `sel_n` is low.
- R4: When `space_mem` is low during the address phase, the cycle is ignored unless `mio_chk_off` is high. When `mio_chk_off` is high, the value of `space_mem` has no effect.
- R5: A cycle whose address bits `[19:WIN_BITS]` differ from the same bits of `BASE_ADDR` is ignored.
- R6: Byte lanes come from `{hi_en_n, address bit 0}`, and `rf_be` bit 1 is the upper lane. The value 00 gives a word (`rf_be`=11). The value 01 gives the upper byte (`rf_be`=10). Both 10 and 11 give the lower byte (`rf_be`=01).
- R7: Let k be the first rising edge at which a decoded cycle's read or write strobe is sampled low. `ready` is low before edge k+1, goes high from edge k+1, and falls at the first edge at which both strobes are sampled high.
- R8: Each decoded write produces exactly one `rf_wr` pulse, one clock long. Its data is `mux_in` as sampled at edge k, with upper-byte data taken from bits 15:8.
- R9: During a decoded read, `mux_oe` is high only while `ready` is high, `rd_n` is low and `wr_n` is high. `mux_out` then carries the addressed word with any disabled byte lane forced to zero, so upper-byte data appears on bits 15:8.
- R10: While `rst_n` is low at a clock edge, the block clears its state, and `ready`, `mux_oe`, `rf_wr` and `rf_rd` are all low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mio_chk_off | input | 1 | High: accept IO-type cycles as well as memory-type cycles |
| addr_strobe | input | 1 | Address phase marker, active high |
| mux_in | input | 16 | Shared address/data lines, input side |
| mux_out | output | 16 | Shared address/data lines, output side |
| mux_oe | output | 1 | Output enable for the shared lines |
| addr_hi | input | 4 | Address bits 19:16 |
| hi_en_n | input | 1 | Upper-lane enable, active low |
| sel_n | input | 1 | Block select, active low |
| space_mem | input | 1 | High for a memory cycle, low for an IO cycle |
| fetch_n | input | 1 | Low marks a program fetch, which is ignored |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ready | output | 1 | Synchronous ready, active high |
| rf_addr | output | WIN_BITS-1 | Register-file word index |
| rf_be | output | 2 | Register-file byte enables |
| rf_wdata | output | 16 | Register-file write data |
| rf_wr | output | 1 | Register-file write pulse |
| rf_rd | output | 1 | Register-file read pulse |
| rf_rdata | input | 16 | Register-file read data, valid while `rf_rd` is high |

## Verification
The bench builds the block with `WIN_BITS`=8 and `BASE_ADDR`=20'hA3400, which gives a window of 128 words. With a window that small, random addresses inside it land on words already written often enough that readback hits earlier upper-byte, lower-byte and word writes. Random addresses outside the window test the R5 rejection from both sides of the window boundary. Random draws of select, fetch, memory/IO and the configuration bit cover every combination of the qualifiers against one expected-hit function.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int HOST_AW = 20;
    localparam int HOST_DW = 16;
    localparam int LANES   = HOST_DW / 8;

    typedef enum logic [1:0] {
        LANE_WORD = 2'd0,
        LANE_HI   = 2'd1,
        LANE_LO   = 2'd2
    } lane_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_RDY  = 2'd2
    } cyc_st_e;

    typedef struct packed {
        logic [HOST_AW-1:0] addr;
        lane_e              lane;
        logic               hit;
    } host_cyc_t;

    // Both high-enable-off encodings fall to the lower lane.
    function automatic lane_e lane_of(input logic hi_en_n, input logic a0);
        case ({hi_en_n, a0})
            2'b00:   return LANE_WORD;
            2'b01:   return LANE_HI;
            default: return LANE_LO;
        endcase
    endfunction

    function automatic logic [LANES-1:0] be_of(input lane_e l);
        case (l)
            LANE_WORD: return 2'b11;
            LANE_HI:   return 2'b10;
            default:   return 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch
    import hbus_pkg::*;
#(
    parameter int                 WIN_BITS  = 8,
    parameter logic [HOST_AW-1:0] BASE_ADDR = 20'hA3400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_strobe,
    input  logic [HOST_DW-1:0] mux_in,
    input  logic [3:0]         addr_hi,
    input  logic               hi_en_n,
    input  logic               sel_n,
    input  logic               space_mem,
    input  logic               fetch_n,
    input  logic               mio_chk_off,
    input  logic               consume,
    output host_cyc_t          cyc
);
    logic [HOST_AW-1:0] full_addr;
    logic               in_window;
    logic               qual_ok;

    assign full_addr = {addr_hi, mux_in};
    assign in_window = full_addr[HOST_AW-1:WIN_BITS] == BASE_ADDR[HOST_AW-1:WIN_BITS];
    assign qual_ok   = !sel_n && fetch_n && (mio_chk_off || space_mem);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (addr_strobe) begin
            cyc.addr <= full_addr;
            cyc.lane <= lane_of(hi_en_n, mux_in[0]);
            cyc.hit  <= qual_ok && in_window;
        end else if (consume) begin
            cyc.hit <= 1'b0;
        end
    end
endmodule

// File: rtl/hbus_cycle_fsm.sv
module hbus_cycle_fsm
    import hbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_n,
    input  logic wr_n,
    output logic start,
    output logic acc_rd,
    output logic acc_wr,
    output logic ready,
    output logic is_read,
    output logic consume
);
    cyc_st_e st;
    logic    strobe_on;

    assign strobe_on = !rd_n || !wr_n;
    assign start     = (st == ST_IDLE) && hit && strobe_on;
    assign acc_rd    = (st == ST_ACC) && is_read;
    assign acc_wr    = (st == ST_ACC) && !is_read;
    assign ready     = (st == ST_RDY);
    assign consume   = (st == ST_RDY) && !strobe_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            is_read <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_ACC;
                    is_read <= !rd_n;
                end
                ST_ACC:  st <= ST_RDY;
                ST_RDY:  if (!strobe_on) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hbus_datapath.sv
module hbus_datapath
    import hbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_DW-1:0] mux_in,
    input  logic [LANES-1:0]   be,
    input  logic               start,
    input  logic               acc_rd,
    input  logic               ready,
    input  logic               is_read,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic [HOST_DW-1:0] rf_rdata,
    output logic [HOST_DW-1:0] wdata,
    output logic [HOST_DW-1:0] mux_out,
    output logic               mux_oe
);
    logic [HOST_DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     wdata <= '0;
        else if (start) wdata <= mux_in;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata_q[g*8 +: 8] <= '0;
            else if (acc_rd)
                rdata_q[g*8 +: 8] <= be[g] ? rf_rdata[g*8 +: 8] : 8'h00;
        end
    end

    assign mux_out = rdata_q;
    assign mux_oe  = ready && is_read && !rd_n && wr_n;
endmodule

// File: rtl/mux_host_slave.sv
module mux_host_slave
    import hbus_pkg::*;
#(
    parameter int                 WIN_BITS  = 8,
    parameter logic [HOST_AW-1:0] BASE_ADDR = 20'hA3400,
    localparam int                RF_AW     = WIN_BITS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mio_chk_off,
    input  logic               addr_strobe,
    input  logic [HOST_DW-1:0] mux_in,
    output logic [HOST_DW-1:0] mux_out,
    output logic               mux_oe,
    input  logic [3:0]         addr_hi,
    input  logic               hi_en_n,
    input  logic               sel_n,
    input  logic               space_mem,
    input  logic               fetch_n,
    input  logic               rd_n,
    input  logic               wr_n,
    output logic               ready,
    output logic [RF_AW-1:0]   rf_addr,
    output logic [LANES-1:0]   rf_be,
    output logic [HOST_DW-1:0] rf_wdata,
    output logic               rf_wr,
    output logic               rf_rd,
    input  logic [HOST_DW-1:0] rf_rdata
);
    host_cyc_t cyc;
    logic      start, consume, is_read;

    hbus_addr_latch #(.WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)) u_latch (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .mux_in(mux_in),
        .addr_hi(addr_hi), .hi_en_n(hi_en_n), .sel_n(sel_n), .space_mem(space_mem),
        .fetch_n(fetch_n), .mio_chk_off(mio_chk_off), .consume(consume), .cyc(cyc)
    );

    hbus_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(cyc.hit), .rd_n(rd_n), .wr_n(wr_n),
        .start(start), .acc_rd(rf_rd), .acc_wr(rf_wr), .ready(ready),
        .is_read(is_read), .consume(consume)
    );

    assign rf_addr = cyc.addr[WIN_BITS-1:1];
    assign rf_be   = be_of(cyc.lane);

    hbus_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .mux_in(mux_in), .be(rf_be), .start(start),
        .acc_rd(rf_rd), .ready(ready), .is_read(is_read), .rd_n(rd_n), .wr_n(wr_n),
        .rf_rdata(rf_rdata), .wdata(rf_wdata), .mux_out(mux_out), .mux_oe(mux_oe)
    );
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ready,
    input logic       mux_oe,
    input logic       rf_rd,
    input logic       rf_wr,
    input logic [1:0] rf_be
);
    a_r7_ready_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd || rf_wr) |=> ready);

    a_r7_ready_has_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rf_rd || rf_wr));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd || rf_wr) |=> !(rf_rd || rf_wr));

    a_r9_drive_in_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        mux_oe |-> (ready && !rd_n && wr_n));

    a_r6_lanes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd || rf_wr) |-> (rf_be != 2'b00));

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ready && !mux_oe && !rf_wr && !rf_rd));
endmodule

bind mux_host_slave hbus_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .ready(ready),
    .mux_oe(mux_oe), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_be(rf_be)
);

// File: tb/mux_host_slave_test.sv
`timescale 1ns/1ps
module mux_host_slave_test;
    localparam int          WB   = 8;
    localparam logic [19:0] BASE = 20'hA3400;
    localparam int          NW   = 1 << (WB - 1);

    logic clk = 0, rst_n = 0;
    logic mio_chk_off = 0, addr_strobe = 0;
    logic [15:0] mux_in = 0, mux_out;
    logic mux_oe;
    logic [3:0] addr_hi = 0;
    logic hi_en_n = 1, sel_n = 1, space_mem = 1, fetch_n = 1, rd_n = 1, wr_n = 1;
    logic ready;
    logic [WB-2:0] rf_addr;
    logic [1:0] rf_be;
    logic [15:0] rf_wdata, rf_rdata;
    logic rf_wr, rf_rd;

    int checks = 0, fails = 0, wr_pulses = 0;
    bit done = 0;
    logic [15:0] rf_mem [NW];
    logic [15:0] shadow [NW];

    always #2 clk = ~clk;

    mux_host_slave #(.WIN_BITS(WB), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .mio_chk_off(mio_chk_off), .addr_strobe(addr_strobe),
        .mux_in(mux_in), .mux_out(mux_out), .mux_oe(mux_oe), .addr_hi(addr_hi),
        .hi_en_n(hi_en_n), .sel_n(sel_n), .space_mem(space_mem), .fetch_n(fetch_n),
        .rd_n(rd_n), .wr_n(wr_n), .ready(ready), .rf_addr(rf_addr), .rf_be(rf_be),
        .rf_wdata(rf_wdata), .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
    );

    // Register file attached to the block's port.
    assign rf_rdata = rf_mem[rf_addr];
    always @(posedge clk) begin
        if (rf_wr) begin
            wr_pulses <= wr_pulses + 1;
            if (rf_be[0]) rf_mem[rf_addr][7:0]  <= rf_wdata[7:0];
            if (rf_be[1]) rf_mem[rf_addr][15:8] <= rf_wdata[15:8];
        end
    end

    function automatic logic [15:0] init_val(int i);
        return 16'h5A00 ^ (16'h0101 * i[15:0]);
    endfunction

    function automatic bit exp_hit(logic [19:0] a, logic s_n, logic f_n, logic m, logic cfg);
        return !s_n && f_n && (m || cfg) && (a[19:WB] == BASE[19:WB]);
    endfunction

    function automatic logic [1:0] exp_be(logic h_n, logic a0);
        if (!h_n && !a0) return 2'b11;
        if (!h_n && a0)  return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] be);
        return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] lane_mask(logic [15:0] w, logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // One host cycle; checks ready timing, drive enable, data and write count.
    task automatic host_cycle(bit is_wr, logic [19:0] a, logic h_n, logic s_n,
                              logic f_n, logic m, logic [15:0] wd, string req);
        bit hit = exp_hit(a, s_n, f_n, m, mio_chk_off);
        logic [1:0] be = exp_be(h_n, a[0]);
        int idx = int'(a[WB-1:1]);
        int wp0 = wr_pulses;
        @(negedge clk);
        addr_strobe = 1; mux_in = a[15:0]; addr_hi = a[19:16];
        hi_en_n = h_n; sel_n = s_n; fetch_n = f_n; space_mem = m;
        @(negedge clk);
        addr_strobe = 0; sel_n = 1; fetch_n = 1;
        mux_in = is_wr ? wd : 16'h0;
        if (is_wr) wr_n = 0; else rd_n = 0;
        @(negedge clk);
        check(ready == 0, "R7", {req, " ready low at cycle start"}, ready, 0);
        @(negedge clk);
        check(ready == hit, hit ? "R7" : req, "ready one clock after strobe", ready, hit);
        if (!is_wr) begin
            check(mux_oe == hit, hit ? "R9" : req, "drive enable in read", mux_oe, hit);
            if (hit) check(mux_out == lane_mask(shadow[idx], be), "R9",
                           {req, " read data lanes"}, mux_out, lane_mask(shadow[idx], be));
        end else begin
            check(mux_oe == 0, "R9", "no drive in write", mux_oe, 0);
        end
        rd_n = 1; wr_n = 1;
        @(negedge clk);
        check(ready == 0 && mux_oe == 0, "R7", "ready falls after strobe release",
              {ready, mux_oe}, 0);
        if (is_wr) begin
            check(wr_pulses - wp0 == int'(hit), hit ? "R8" : req, "write pulse count",
                  wr_pulses - wp0, hit);
            if (hit) shadow[idx] = merge(shadow[idx], wd, be);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [19:0] a;
        for (int i = 0; i < NW; i++) begin
            rf_mem[i] = init_val(i);
            shadow[i] = init_val(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ready && !mux_oe && !rf_wr && !rf_rd, "R10", "outputs quiet in reset",
              {ready, mux_oe, rf_wr, rf_rd}, 0);
        rst_n = 1;

        // R1 / R6 word write and readback
        host_cycle(1, BASE | 20'h10, 0, 0, 1, 1, 16'hBEEF, "R1");
        host_cycle(0, BASE | 20'h10, 0, 0, 1, 1, 0, "R1");
        // R6 upper byte ({0,1}), lower byte both encodings ({1,0},{1,1})
        host_cycle(1, BASE | 20'h21, 0, 0, 1, 1, 16'hC3A5, "R6");
        host_cycle(0, BASE | 20'h20, 0, 0, 1, 1, 0, "R6");
        host_cycle(1, BASE | 20'h30, 1, 0, 1, 1, 16'h1177, "R6");
        host_cycle(1, BASE | 20'h33, 1, 0, 1, 1, 16'h22E4, "R6");
        host_cycle(0, BASE | 20'h30, 0, 0, 1, 1, 0, "R6");
        host_cycle(0, BASE | 20'h33, 1, 0, 1, 1, 0, "R6");
        host_cycle(0, BASE | 20'h21, 0, 0, 1, 1, 0, "R6");
        // R2 / R3 / R4 / R5 ignored cycles, then readback proves no change
        host_cycle(1, BASE | 20'h40, 0, 1, 1, 1, 16'hDEAD, "R2");
        host_cycle(1, BASE | 20'h40, 0, 0, 0, 1, 16'hDEAD, "R3");
        host_cycle(1, BASE | 20'h40, 0, 0, 1, 0, 16'hDEAD, "R4");
        host_cycle(1, (BASE ^ 20'h00100) | 20'h40, 0, 0, 1, 1, 16'hDEAD, "R5");
        host_cycle(0, BASE | 20'h40, 0, 0, 1, 1, 0, "R2");
        mio_chk_off = 1;
        host_cycle(1, BASE | 20'h40, 0, 0, 1, 0, 16'h4242, "R4");
        host_cycle(0, BASE | 20'h40, 0, 0, 1, 0, 0, "R4");
        mio_chk_off = 0;

        // Random mix
        void'($urandom(32'h1234));
        for (int n = 0; n < 300; n++) begin
            a = ($urandom % 5 == 0) ? 20'($urandom) : (BASE | 20'($urandom % 256));
            mio_chk_off = ($urandom % 4 == 0);
            host_cycle($urandom % 2, a, $urandom % 2, ($urandom % 6 == 0),
                       ($urandom % 6 != 0), ($urandom % 5 != 0), 16'($urandom), "R1");
        end

        done = 1;
        report();
    end
endmodule